// File: doc/BRIEF.md
# Challenge-Response Token Enable Checker

This block sits inside a volatile programmable device and holds the user function switched off until an external nonvolatile companion chip shows that it knows a shared secret. Coming out of reset, it takes a nonzero 32-bit challenge from a free-running LFSR and sends it to the companion over a byte-serial transmit link. It then sends a one-byte token request and collects a 4-byte token on the receive link. At the same time it computes the expected token from the same challenge. If the two tokens are equal, the enable output is asserted.

While the enable is high, the block issues a new request after every `PERIOD_CYC` idle cycles. The companion must advance its copy of the challenge by one LFSR step and answer with the matching token. The block drops the enable if a token does not match or if no full token arrives within `TIMEOUT_CYC` cycles. After a drop it stays silent for `BACKOFF_CYC` cycles and then starts over with a fresh challenge.

The transmit link has no ready signal, so the companion must accept one byte per cycle whenever `tx_valid_o` is high. The token function is a keyed LFSR mix. It stands in for a real cryptographic function.

Top module: `tg_token_gate`

## Requirements
- R1: While `rst_n` is low, `user_en_o` and `tx_valid_o` are both 0.
- R2: After reset, and after each back-off, the block sends a challenge frame. The frame is 5 bytes on consecutive cycles: opcode 8'hA5, then the 32-bit challenge, most significant byte first. The challenge is never zero.
- R3: Right after a challenge frame, the block sends a single request byte 8'h5A. `tx_valid_o` stays low while the block waits for the token.
- R4: The token is 4 bytes on `rx_byte_i`, qualified by `rx_valid_i`, most significant byte first. Idle cycles between the bytes are allowed. The expected token is (challenge XOR `TOKEN_KEY`), advanced 32 times by the step s' = (s<<1) XOR (s[31] ? 32'h04C11DB7 : 0). A match sets `user_en_o`.
- R5: `user_en_o` stays 0 until a matching token has been received. A mismatching answer to a fresh challenge leaves it 0 and leads to back-off and a new challenge frame.
- R6: While enabled, the block sends a request byte after `PERIOD_CYC` idle cycles, using the challenge advanced by one step. A matching reply keeps `user_en_o` at 1 without any gap.
- R7: A mismatching token clears `user_en_o` on the second cycle after its last byte.
- R8: Suppose fewer than four token bytes have arrived after `TIMEOUT_CYC` cycles of waiting. Waiting starts the second cycle after the request byte appears. The enable then drops, `tx_valid_o` stays low for `BACKOFF_CYC` cycles, and a new challenge frame follows.
- R9: Receive bytes outside the window from the request byte to the end of waiting are ignored, as are bytes beyond the fourth. They do not change `user_en_o` or the outcome of the next exchange.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid_o | output | 1 | Transmit byte present this cycle |
| tx_byte_o | output | 8 | Transmit byte to the companion |
| rx_valid_i | input | 1 | Receive byte present this cycle |
| rx_byte_i | input | 8 | Receive byte from the companion |
| user_en_o | output | 1 | Enable for the protected user function |

## Verification
The assertions assume that the companion never sends more than a token's worth of bytes while the block is waiting. They also assume that reset is held long enough for the asynchronous clear to settle before the first checked edge. The bench plays the companion. It drives the receive link only in the cycles after it has seen a request byte, except for deliberate junk bytes, which it sends only during the idle period. It keeps reply delays and byte gaps well under the timeout, except in the one vector that stays silent on purpose.

// File: rtl/tg_pkg.sv
package tg_pkg;

  localparam logic [31:0] TG_POLY      = 32'h04C1_1DB7;
  localparam logic [31:0] TG_SEED      = 32'h1D2C_3B4A;
  localparam logic [7:0]  TG_OP_CHAL   = 8'hA5;
  localparam logic [7:0]  TG_OP_REQ    = 8'h5A;
  localparam int          TG_MIX_STEPS = 32;

  typedef enum logic [2:0] {
    ST_GEN,
    ST_CHAL_TX,
    ST_REQ_TX,
    ST_WAIT,
    ST_IDLE,
    ST_BACKOFF
  } tg_state_e;

  // one Galois LFSR step, shift towards the MSB
  function automatic logic [31:0] tg_step(input logic [31:0] s);
    tg_step = {s[30:0], 1'b0} ^ (s[31] ? TG_POLY : 32'h0);
  endfunction

  // keyed mixing: XOR with the key, then TG_MIX_STEPS steps
  function automatic logic [31:0] tg_token(input logic [31:0] c,
                                           input logic [31:0] key);
    logic [31:0] x;
    x = c ^ key;
    for (int i = 0; i < TG_MIX_STEPS; i++) begin
      x = tg_step(x);
    end
    tg_token = x;
  endfunction

endpackage

// File: rtl/tg_entropy.sv
// Free-running LFSR, deliberately not reset: its phase at the end of
// reset depends on how long the device sat powered before release.
module tg_entropy
  import tg_pkg::*;
#(
  parameter logic [31:0] SEED = TG_SEED
) (
  input  logic        clk,
  output logic [31:0] ent_o
);
  logic [31:0] ent_q;

  always_ff @(posedge clk) begin
    ent_q <= (ent_q == 32'h0) ? SEED : tg_step(ent_q);
  end

  assign ent_o = ent_q;
endmodule

// File: rtl/tg_tx.sv
// Byte serializer: a challenge frame (opcode + 4 bytes) or a lone request.
module tg_tx
  import tg_pkg::*;
#(
  parameter int CHAL_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_chal_i,
  input  logic                    load_req_i,
  input  logic [8*CHAL_BYTES-1:0] chal_i,
  output logic                    tx_valid_o,
  output logic [7:0]              tx_byte_o,
  output logic                    busy_o
);
  localparam int FRAME_W = 8 * (CHAL_BYTES + 1);
  localparam int CNT_W   = $clog2(CHAL_BYTES + 2);
  localparam logic [CNT_W-1:0] FRAME_LEN = CNT_W'(CHAL_BYTES + 1);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_chal_i) begin
      sh_q  <= {TG_OP_CHAL, chal_i};
      cnt_q <= FRAME_LEN;
    end else if (load_req_i) begin
      sh_q  <= {TG_OP_REQ, {(8*CHAL_BYTES){1'b0}}};
      cnt_q <= CNT_W'(1);
    end else if (cnt_q != '0) begin
      sh_q  <= {sh_q[FRAME_W-9:0], 8'h00};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tx_valid_o = (cnt_q != '0);
  assign busy_o     = (cnt_q != '0);
  assign tx_byte_o  = sh_q[FRAME_W-1 -: 8];
endmodule

// File: rtl/tg_rx.sv
// Token assembler: collects BYTES bytes MSB first while enabled.
module tg_rx #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               rx_valid_i,
  input  logic [7:0]         rx_byte_i,
  output logic [8*BYTES-1:0] word_o,
  output logic               full_o
);
  localparam int CNT_W = $clog2(BYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTES);

  logic [8*BYTES-1:0] word_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (!en_i) begin
      cnt_q  <= '0;
    end else if (rx_valid_i && cnt_q != LAST) begin
      word_q <= {word_q[8*BYTES-9:0], rx_byte_i};
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign word_o = word_q;
  assign full_o = (cnt_q == LAST);
endmodule

// File: rtl/tg_seq.sv
// Exchange sequencer: challenge, request, wait, compare, period, back-off.
module tg_seq
  import tg_pkg::*;
#(
  parameter int          PERIOD_CYC  = 1 << 20,
  parameter int          TIMEOUT_CYC = 4096,
  parameter int          BACKOFF_CYC = 1024,
  parameter logic [31:0] TOKEN_KEY   = 32'h3C6E_F372,
  parameter logic [31:0] CHAL_SEED   = TG_SEED
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ent_i,
  input  logic        tx_busy_i,
  input  logic        rx_full_i,
  input  logic [31:0] rx_word_i,
  output logic        load_chal_o,
  output logic        load_req_o,
  output logic [31:0] tx_chal_o,
  output logic        rx_en_o,
  output logic        user_en_o,
  output logic [31:0] chal_o,
  output logic        ev_gen_o,
  output logic        ev_pass_o,
  output logic        ev_fail_o,
  output logic        ev_timeout_o,
  output logic        ev_period_o,
  output logic        in_wait_o,
  output logic        in_backoff_o
);
  localparam int MAX_AB = (PERIOD_CYC > TIMEOUT_CYC) ? PERIOD_CYC : TIMEOUT_CYC;
  localparam int MAX_C  = (MAX_AB > BACKOFF_CYC) ? MAX_AB : BACKOFF_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] PER_LAST = CNT_W'(PERIOD_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] BKO_LAST = CNT_W'(BACKOFF_CYC - 1);

  tg_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [31:0]      chal_q, chal_d;
  logic             en_q, en_d;
  logic             tok_match;

  assign tok_match = (rx_word_i == tg_token(chal_q, TOKEN_KEY));

  always_comb begin
    st_d         = st_q;
    cnt_d        = cnt_q;
    chal_d       = chal_q;
    en_d         = en_q;
    load_chal_o  = 1'b0;
    load_req_o   = 1'b0;
    ev_gen_o     = 1'b0;
    ev_pass_o    = 1'b0;
    ev_fail_o    = 1'b0;
    ev_timeout_o = 1'b0;
    ev_period_o  = 1'b0;
    case (st_q)
      ST_GEN: begin
        chal_d      = (ent_i == 32'h0) ? CHAL_SEED : ent_i;
        load_chal_o = 1'b1;
        ev_gen_o    = 1'b1;
        st_d        = ST_CHAL_TX;
      end
      ST_CHAL_TX: begin
        if (!tx_busy_i) begin
          load_req_o = 1'b1;
          st_d       = ST_REQ_TX;
        end
      end
      ST_REQ_TX: begin
        if (!tx_busy_i) begin
          cnt_d = '0;
          st_d  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (rx_full_i) begin
          cnt_d = '0;
          if (tok_match) begin
            ev_pass_o = 1'b1;
            en_d      = 1'b1;
            st_d      = ST_IDLE;
          end else begin
            ev_fail_o = 1'b1;
            en_d      = 1'b0;
            st_d      = ST_BACKOFF;
          end
        end else if (cnt_q == TMO_LAST) begin
          ev_timeout_o = 1'b1;
          ev_fail_o    = 1'b1;
          en_d         = 1'b0;
          cnt_d        = '0;
          st_d         = ST_BACKOFF;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_IDLE: begin
        if (cnt_q == PER_LAST) begin
          ev_period_o = 1'b1;
          chal_d      = tg_step(chal_q);
          load_req_o  = 1'b1;
          st_d        = ST_REQ_TX;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_BACKOFF: begin
        if (cnt_q == BKO_LAST) begin
          cnt_d = '0;
          st_d  = ST_GEN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_GEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_GEN;
      cnt_q  <= '0;
      chal_q <= '0;
      en_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      chal_q <= chal_d;
      en_q   <= en_d;
    end
  end

  assign tx_chal_o    = chal_d;
  assign chal_o       = chal_q;
  assign user_en_o    = en_q;
  assign rx_en_o      = (st_q == ST_REQ_TX) || (st_q == ST_WAIT);
  assign in_wait_o    = (st_q == ST_WAIT);
  assign in_backoff_o = (st_q == ST_BACKOFF);
endmodule

// File: rtl/tg_token_gate.sv
module tg_token_gate
  import tg_pkg::*;
#(
  parameter int          PERIOD_CYC  = 1 << 20,
  parameter int          TIMEOUT_CYC = 4096,
  parameter int          BACKOFF_CYC = 1024,
  parameter logic [31:0] TOKEN_KEY   = 32'h3C6E_F372,
  parameter logic [31:0] CHAL_SEED   = TG_SEED
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       tx_valid_o,
  output logic [7:0] tx_byte_o,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_byte_i,
  output logic       user_en_o
);
  localparam int TOK_BYTES = 4;

  logic [31:0] ent;
  logic [31:0] tx_chal;
  logic [31:0] chal;
  logic [31:0] rx_word;
  logic        tx_busy, rx_full, rx_en;
  logic        load_chal, load_req;
  // named internal events, observed by the bound checker
  logic        ev_gen, ev_pass, ev_fail, ev_timeout, ev_period;
  logic        in_wait, in_backoff;

  tg_entropy #(.SEED(CHAL_SEED)) u_ent (
    .clk   (clk),
    .ent_o (ent)
  );

  tg_tx #(.CHAL_BYTES(TOK_BYTES)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_chal_i (load_chal),
    .load_req_i  (load_req),
    .chal_i      (tx_chal),
    .tx_valid_o  (tx_valid_o),
    .tx_byte_o   (tx_byte_o),
    .busy_o      (tx_busy)
  );

  tg_rx #(.BYTES(TOK_BYTES)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (rx_en),
    .rx_valid_i (rx_valid_i),
    .rx_byte_i  (rx_byte_i),
    .word_o     (rx_word),
    .full_o     (rx_full)
  );

  tg_seq #(
    .PERIOD_CYC  (PERIOD_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .BACKOFF_CYC (BACKOFF_CYC),
    .TOKEN_KEY   (TOKEN_KEY),
    .CHAL_SEED   (CHAL_SEED)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .ent_i        (ent),
    .tx_busy_i    (tx_busy),
    .rx_full_i    (rx_full),
    .rx_word_i    (rx_word),
    .load_chal_o  (load_chal),
    .load_req_o   (load_req),
    .tx_chal_o    (tx_chal),
    .rx_en_o      (rx_en),
    .user_en_o    (user_en_o),
    .chal_o       (chal),
    .ev_gen_o     (ev_gen),
    .ev_pass_o    (ev_pass),
    .ev_fail_o    (ev_fail),
    .ev_timeout_o (ev_timeout),
    .ev_period_o  (ev_period),
    .in_wait_o    (in_wait),
    .in_backoff_o (in_backoff)
  );
endmodule

// File: rtl/tg_token_gate_chk.sv
module tg_token_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        user_en_o,
  input logic        tx_valid_o,
  input logic        ev_gen,
  input logic        ev_pass,
  input logic        ev_fail,
  input logic        ev_timeout,
  input logic        ev_period,
  input logic        in_wait,
  input logic        in_backoff,
  input logic [31:0] chal
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!user_en_o && !tx_valid_o);
    end
  end

  assert_chal_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_gen |=> (chal != 32'h0));

  assert_wait_tx_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !tx_valid_o);

  assert_en_needs_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(user_en_o) |-> $past(ev_pass));

  assert_period_when_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_period |-> user_en_o);

  assert_fail_drops_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |=> !user_en_o);

  assert_timeout_backoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> (in_backoff && !user_en_o));

  assert_backoff_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_backoff |-> (!user_en_o && !tx_valid_o));

endmodule

bind tg_token_gate tg_token_gate_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .user_en_o  (user_en_o),
  .tx_valid_o (tx_valid_o),
  .ev_gen     (ev_gen),
  .ev_pass    (ev_pass),
  .ev_fail    (ev_fail),
  .ev_timeout (ev_timeout),
  .ev_period  (ev_period),
  .in_wait    (in_wait),
  .in_backoff (in_backoff),
  .chal       (chal)
);

// File: tb/tg_token_gate_tb.sv
module tg_token_gate_tb_top;
  localparam int PER = 40;
  localparam int TMO = 20;
  localparam int BKO = 16;
  localparam logic [31:0] KEY = 32'h3C6E_F372;

  typedef struct packed {
    logic [31:0] flip;    // XOR applied to the correct token
    logic [7:0]  delay;   // cycles before first token byte
    logic [7:0]  gap;     // idle cycles between token bytes
    logic        silent;  // companion never answers
    logic        junk;    // inject stray bytes after this round
    logic        exp_en;  // expected enable afterwards
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{32'h0,         8'd2, 8'd0, 1'b0, 1'b0, 1'b1},
    '{32'h0,         8'd0, 8'd0, 1'b0, 1'b1, 1'b1},
    '{32'h0,         8'd3, 8'd2, 1'b0, 1'b0, 1'b1},
    '{32'h0000_0100, 8'd1, 8'd0, 1'b0, 1'b0, 1'b0},
    '{32'h0,         8'd0, 8'd0, 1'b0, 1'b0, 1'b1},
    '{32'h0,         8'd0, 8'd0, 1'b1, 1'b0, 1'b0},
    '{32'h8000_0000, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0},
    '{32'h0,         8'd4, 8'd1, 1'b0, 1'b0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_valid;
  logic [7:0] tx_byte;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       user_en;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tg_token_gate #(
    .PERIOD_CYC  (PER),
    .TIMEOUT_CYC (TMO),
    .BACKOFF_CYC (BKO),
    .TOKEN_KEY   (KEY)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_valid_o (tx_valid),
    .tx_byte_o  (tx_byte),
    .rx_valid_i (rx_valid),
    .rx_byte_i  (rx_byte),
    .user_en_o  (user_en)
  );

  // reference model, written bit by bit
  function automatic logic [31:0] ref_step(input logic [31:0] s);
    logic msb;
    msb = s[31];
    s   = s << 1;
    if (msb) s = s ^ 32'h04C1_1DB7;
    return s;
  endfunction

  function automatic logic [31:0] ref_token(input logic [31:0] c);
    logic [31:0] x;
    x = c ^ KEY;
    repeat (32) x = ref_step(x);
    return x;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic get_byte(output logic [7:0] b);
    @(negedge clk);
    while (!tx_valid) @(negedge clk);
    b = tx_byte;
  endtask

  task automatic send_token(input logic [31:0] t, input int gap);
    for (int k = 3; k >= 0; k--) begin
      rx_valid = 1'b1;
      rx_byte  = t[8*k +: 8];
      @(negedge clk);
      rx_valid = 1'b0;
      repeat (gap) @(negedge clk);
    end
    rx_valid = 1'b0;
  endtask

  task automatic read_challenge(output logic [31:0] c);
    logic [7:0] b;
    get_byte(b);
    check(b == 8'hA5, "R2 challenge opcode", {24'h0, b}, 32'hA5);
    c = 32'h0;
    for (int k = 0; k < 4; k++) begin
      get_byte(b);
      c = {c[23:0], b};
    end
    check(c != 32'h0, "R2 challenge nonzero", c, 32'h1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] chal;
    logic [7:0]  b;
    logic        need_chal;
    logic        prev_en;

    // R1: quiet during reset
    repeat (5) @(negedge clk);
    check(user_en == 1'b0, "R1 enable low in reset", {31'h0, user_en}, 32'h0);
    check(tx_valid == 1'b0, "R1 tx idle in reset", {31'h0, tx_valid}, 32'h0);
    rst_n = 1'b1;

    need_chal = 1'b1;
    chal = 32'h0;
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      if (need_chal) begin
        read_challenge(chal);
        check(user_en == 1'b0, "R5 enable low before token", {31'h0, user_en}, 32'h0);
      end else begin
        chal = ref_step(chal);
      end
      get_byte(b);
      check(b == 8'h5A, "R3 request byte", {24'h0, b}, 32'h5A);
      prev_en = user_en;
      if (!need_chal)
        check(prev_en == 1'b1, "R6 enable held across period", {31'h0, prev_en}, 32'h1);
      if (v.silent) begin
        repeat (TMO / 2) @(negedge clk);
        check(user_en == prev_en, "R8 enable held while waiting", {31'h0, user_en}, {31'h0, prev_en});
        repeat (TMO) @(negedge clk);
        check(user_en == 1'b0, "R8 timeout drops enable", {31'h0, user_en}, 32'h0);
        for (int q = 0; q < 4; q++) begin
          @(negedge clk);
          check(tx_valid == 1'b0, "R8 back-off keeps tx quiet", {31'h0, tx_valid}, 32'h0);
        end
      end else begin
        repeat (int'(v.delay)) @(negedge clk);
        send_token(ref_token(chal) ^ v.flip, int'(v.gap));
        repeat (3) @(negedge clk);
        if (v.exp_en)
          check(user_en == 1'b1, "R4 matching token enables", {31'h0, user_en}, 32'h1);
        else if (need_chal)
          check(user_en == 1'b0, "R5 mismatch on fresh challenge", {31'h0, user_en}, 32'h0);
        else
          check(user_en == 1'b0, "R7 mismatch drops enable", {31'h0, user_en}, 32'h0);
        if (!v.exp_en) begin
          for (int q = 0; q < BKO / 2; q++) begin
            @(negedge clk);
            check(tx_valid == 1'b0, "R8 back-off keeps tx quiet", {31'h0, tx_valid}, 32'h0);
          end
        end
      end
      if (v.junk) begin
        // R9: stray bytes while idle, then a too-long burst is harmless
        for (int q = 0; q < 6; q++) begin
          rx_valid = 1'b1;
          rx_byte  = 8'hC3 ^ 8'(q);
          @(negedge clk);
        end
        rx_valid = 1'b0;
        @(negedge clk);
        check(user_en == 1'b1, "R9 stray bytes ignored", {31'h0, user_en}, 32'h1);
      end
      need_chal = !v.exp_en;
    end

    // R1: reset while enabled, then a clean restart (R2, R4)
    check(user_en == 1'b1, "R6 enabled before reset test", {31'h0, user_en}, 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    check(user_en == 1'b0, "R1 reset clears enable", {31'h0, user_en}, 32'h0);
    check(tx_valid == 1'b0, "R1 reset clears tx", {31'h0, tx_valid}, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    read_challenge(chal);
    get_byte(b);
    check(b == 8'h5A, "R3 request after restart", {24'h0, b}, 32'h5A);
    send_token(ref_token(chal), 0);
    repeat (3) @(negedge clk);
    check(user_en == 1'b1, "R4 enable after restart", {31'h0, user_en}, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule